// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block services a cache read miss by fetching the whole line over a memory bus that is narrower than the line. With the default parameters a line is 32 bytes and each bus beat carries 8 bytes, so one fill takes four beats. Fetching does not start at the beginning of the line. It starts with the chunk that contains the missed byte and then wraps around the line. That first chunk goes to the core the cycle after it arrives, so the core can resume before the rest of the line is in.

Each returned beat is placed in its own slot of a fill buffer. Once the last beat is in, the controller writes the assembled line into the cache data array in a single cycle. While a fill is in progress the controller reports busy and refuses new miss requests. Tag lookup, victim selection, write-back and bus arbitration are handled by neighbouring logic.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: A miss request presented while `busy_o` is low is accepted at that clock edge. `busy_o` is high from the next cycle up to and including the array-write cycle, and low in the cycle after it.
- R2: A miss request presented while `busy_o` is high is ignored. The fill in progress completes with its own line address and data.
- R3: The chunk index is miss address bits [4:3] (the critical index c). Chunk requests are issued in the order (c+n) mod 4 for n = 0..3. Each request address is the line address with bits [4:3] set to the chunk index and bits [2:0] zero. For a miss at 0x95 the order is 0x90, 0x98, 0x80, 0x88.
- R4: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and its address does not change.
- R5: In the cycle after the first response beat is captured, `early_valid_o` is high for exactly one cycle. In that cycle `early_data_o` holds that beat and `early_addr_o` holds the line address (miss address with bits [4:0] zero). `early_valid_o` stays low for all later beats.
- R6: Response beat n is stored in line chunk (c+n) mod 4. On the array write port, chunk k occupies `arr_data_o` bits [64k+63:64k].
- R7: `arr_we_o` is high for exactly one cycle, the cycle right after the fourth beat is captured, and in that cycle `arr_addr_o` is the line address.
- R8: A response beat that arrives while idle, or while no chunk request is outstanding, is ignored. It produces no early pulse and does not change the buffered line.
- R9: While reset is low, and in the first cycle after it, `busy_o`, `mem_req_valid_o`, `early_valid_o` and `arr_we_o` are low. A reset in the middle of a fill abandons that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request strobe |
| miss_addr_i | input | 32 | Byte address of the missed access |
| busy_o | output | 1 | Fill in progress; new misses are refused |
| mem_req_valid_o | output | 1 | Chunk request valid |
| mem_req_ready_i | input | 1 | Bus accepts the chunk request |
| mem_req_addr_o | output | 32 | Chunk-aligned request address |
| mem_rsp_valid_i | input | 1 | Response beat valid; responses return in request order |
| mem_rsp_data_i | input | 64 | Response beat data |
| early_valid_o | output | 1 | One-cycle strobe for the critical chunk |
| early_addr_o | output | 32 | Line address of the critical chunk |
| early_data_o | output | 64 | Critical chunk data |
| arr_we_o | output | 1 | Full-line array write enable |
| arr_addr_o | output | 32 | Line address for the array write |
| arr_data_o | output | 256 | Assembled line; chunk k in bits [64k+63:64k] |

## Verification
The assertions watch on every cycle the properties that relate a cycle to the one before or after it: busy rising on acceptance, a refused miss leaving the line address unchanged, a stalled request holding steady, consecutive request chunk indices stepping by one mod 4, and single-cycle pulses for the early strobe and the array write, the latter following a response beat. Only the bench scenarios can show the data path: that each beat lands in the correct slot for every critical index, that the early chunk carries the right data, and that stray responses leave the line unchanged. The scenarios cover all four critical offsets under varying bus stall and response gap lengths, plus reset in mid-fill.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } fill_st_e;
endpackage

// File: rtl/cwf_wrap_seq.sv
// Maps a step count onto the wrapped chunk index; the beat count must be a power of two.
module cwf_wrap_seq #(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] crit_i,
  input  logic [IDX_W-1:0] step_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o = crit_i + step_i;
endmodule

// File: rtl/cwf_fill_buf.sv
module cwf_fill_buf #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 64,
  parameter int IDX_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [BEAT_W-1:0]       wr_data_i,
  output logic [BEATS*BEAT_W-1:0] line_o
);
  for (genvar s = 0; s < BEATS; s++) begin : g_slot
    logic [BEAT_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(s)) begin
        slot_q <= wr_data_i;
      end
    end
    assign line_o[s*BEAT_W +: BEAT_W] = slot_q;
  end
endmodule

// File: rtl/cwf_fill_fsm.sv
module cwf_fill_fsm
  import cwf_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 27,
  parameter int BEAT_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [TAG_W-1:0]  miss_tag_i,
  input  logic [IDX_W-1:0]  miss_crit_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  input  logic [BEAT_W-1:0] rsp_data_i,
  output logic              busy_o,
  output logic              req_valid_o,
  output logic [IDX_W-1:0]  req_step_o,
  output logic [IDX_W-1:0]  rsp_step_o,
  output logic              capture_o,
  output logic [IDX_W-1:0]  crit_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              early_valid_o,
  output logic [BEAT_W-1:0] early_data_o,
  output logic              arr_we_o
);
  localparam int CNT_W = IDX_W + 1;

  fill_st_e          state_q;
  logic [CNT_W-1:0]  req_cnt_q, rsp_cnt_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  crit_q;
  logic              early_valid_q;
  logic [BEAT_W-1:0] early_data_q;
  logic              req_fire, last_beat;

  assign req_valid_o = (state_q == ST_FILL) && (req_cnt_q < CNT_W'(BEATS));
  assign req_fire    = req_valid_o && req_ready_i;
  // only beats with a request outstanding are taken
  assign capture_o   = (state_q == ST_FILL) && rsp_valid_i && (rsp_cnt_q != req_cnt_q);
  assign last_beat   = capture_o && (rsp_cnt_q == CNT_W'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      req_cnt_q     <= '0;
      rsp_cnt_q     <= '0;
      tag_q         <= '0;
      crit_q        <= '0;
      early_valid_q <= 1'b0;
      early_data_q  <= '0;
    end else begin
      early_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (miss_valid_i) begin
            tag_q     <= miss_tag_i;
            crit_q    <= miss_crit_i;
            req_cnt_q <= '0;
            rsp_cnt_q <= '0;
            state_q   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (req_fire) req_cnt_q <= req_cnt_q + 1'b1;
          if (capture_o) begin
            rsp_cnt_q <= rsp_cnt_q + 1'b1;
            if (rsp_cnt_q == '0) begin
              early_valid_q <= 1'b1;
              early_data_q  <= rsp_data_i;
            end
            if (last_beat) state_q <= ST_WRITE;
          end
        end
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign req_step_o    = req_cnt_q[IDX_W-1:0];
  assign rsp_step_o    = rsp_cnt_q[IDX_W-1:0];
  assign crit_o        = crit_q;
  assign tag_o         = tag_q;
  assign early_valid_o = early_valid_q;
  assign early_data_o  = early_data_q;
  assign arr_we_o      = (state_q == ST_WRITE);

  AST_EARLY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_valid_o |=> !early_valid_o); // R5
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |=> (!arr_we_o && !busy_o)); // R7
  AST_WE_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> $past(rsp_valid_i)); // R7
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    miss_valid_i,
  input  logic [ADDR_W-1:0]       miss_addr_i,
  output logic                    busy_o,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic [ADDR_W-1:0]       mem_req_addr_o,
  input  logic                    mem_rsp_valid_i,
  input  logic [8*BEAT_BYTES-1:0] mem_rsp_data_i,
  output logic                    early_valid_o,
  output logic [ADDR_W-1:0]       early_addr_o,
  output logic [8*BEAT_BYTES-1:0] early_data_o,
  output logic                    arr_we_o,
  output logic [ADDR_W-1:0]       arr_addr_o,
  output logic [8*LINE_BYTES-1:0] arr_data_o
);
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
  localparam int IDX_W      = $clog2(BEATS);
  localparam int OFF_W      = $clog2(BEAT_BYTES);
  localparam int LINE_OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W      = ADDR_W - LINE_OFF_W;
  localparam int BEAT_W     = 8 * BEAT_BYTES;

  logic [IDX_W-1:0] req_step, rsp_step, crit, req_idx, rsp_idx;
  logic [TAG_W-1:0] tag;
  logic             capture;
  logic             unused_off;

  assign unused_off = ^miss_addr_i[OFF_W-1:0];

  cwf_fill_fsm #(
    .BEATS (BEATS),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .BEAT_W(BEAT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .miss_tag_i   (miss_addr_i[ADDR_W-1:LINE_OFF_W]),
    .miss_crit_i  (miss_addr_i[LINE_OFF_W-1:OFF_W]),
    .req_ready_i  (mem_req_ready_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .rsp_data_i   (mem_rsp_data_i),
    .busy_o       (busy_o),
    .req_valid_o  (mem_req_valid_o),
    .req_step_o   (req_step),
    .rsp_step_o   (rsp_step),
    .capture_o    (capture),
    .crit_o       (crit),
    .tag_o        (tag),
    .early_valid_o(early_valid_o),
    .early_data_o (early_data_o),
    .arr_we_o     (arr_we_o)
  );

  cwf_wrap_seq #(.IDX_W(IDX_W)) u_req_seq (
    .crit_i(crit), .step_i(req_step), .idx_o(req_idx)
  );

  cwf_wrap_seq #(.IDX_W(IDX_W)) u_rsp_seq (
    .crit_i(crit), .step_i(rsp_step), .idx_o(rsp_idx)
  );

  cwf_fill_buf #(
    .BEATS (BEATS),
    .BEAT_W(BEAT_W),
    .IDX_W (IDX_W)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (capture),
    .wr_idx_i (rsp_idx),
    .wr_data_i(mem_rsp_data_i),
    .line_o   (arr_data_o)
  );

  assign mem_req_addr_o = {tag, req_idx, {OFF_W{1'b0}}};
  assign early_addr_o   = {tag, {LINE_OFF_W{1'b0}}};
  assign arr_addr_o     = {tag, {LINE_OFF_W{1'b0}}};

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && !busy_o) |=> busy_o); // R1
  AST_BUSY_IGNORES_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && busy_o) |=> $stable(arr_addr_o)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o))); // R4
  AST_REQ_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> (!mem_req_valid_o ||
      (mem_req_addr_o[LINE_OFF_W-1:OFF_W] ==
       IDX_W'($past(mem_req_addr_o[LINE_OFF_W-1:OFF_W]) + 1'b1)))); // R3
endmodule

// File: tb/cwf_fill_ctrl_tb.sv
`timescale 1ns/1ps
module cwf_fill_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic [31:0]  miss_addr = '0;
  logic         busy;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [31:0]  req_addr;
  logic         rsp_valid = 1'b0;
  logic [63:0]  rsp_data = '0;
  logic         early_valid;
  logic [31:0]  early_addr;
  logic [63:0]  early_data;
  logic         arr_we;
  logic [31:0]  arr_addr;
  logic [255:0] arr_data;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cwf_fill_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr), .busy_o(busy),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .early_valid_o(early_valid), .early_addr_o(early_addr), .early_data_o(early_data),
    .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_data_o(arr_data)
  );

  // {miss address, request stall cycles, response gap cycles}
  localparam logic [35:0] VEC [0:7] = '{
    {32'h0000_0095, 2'd0, 2'd0},
    {32'h1234_5678, 2'd1, 2'd0},
    {32'hABCD_EF00, 2'd0, 2'd1},
    {32'h0F0F_0F0A, 2'd2, 2'd2},
    {32'hFFFF_FFFF, 2'd3, 2'd1},
    {32'h0000_0010, 2'd1, 2'd3},
    {32'h8000_0008, 2'd0, 2'd0},
    {32'h5555_5567, 2'd2, 2'd0}
  };

  function automatic logic [63:0] mdat(input logic [31:0] a);
    return {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_fill(input logic [31:0] addr, input int stall, input int gap,
                         input bit stray, input bit extra_miss);
    logic [31:0]  line;
    logic [1:0]   crit;
    logic [255:0] exp_line;
    line = addr & ~32'h1F;
    crit = addr[4:3];
    for (int k = 0; k < 4; k++) exp_line[64*k +: 64] = mdat(line | (k << 3));
    miss_valid = 1'b1;
    miss_addr  = addr;
    cyc();
    miss_valid = 1'b0;
    chk(busy == 1'b1, "R1 busy after accept", 256'(busy), 256'(1));
    if (stray) begin
      rsp_valid = 1'b1;
      rsp_data  = 64'hDEAD_BEEF_0BAD_F00D;
      cyc();
      rsp_valid = 1'b0;
      chk(early_valid == 1'b0, "R8 stray beat no early", 256'(early_valid), 256'(0));
    end
    for (int n = 0; n < 4; n++) begin
      logic [1:0]  idx;
      logic [31:0] ca;
      idx = crit + 2'(n);
      ca  = line | (32'(idx) << 3);
      chk(req_valid && req_addr == ca, "R3 request order", 256'(req_addr), 256'(ca));
      for (int s = 0; s < stall; s++) begin
        cyc();
        chk(req_valid && req_addr == ca, "R4 stalled request held", 256'(req_addr), 256'(ca));
      end
      req_ready = 1'b1;
      if (extra_miss && n == 1) begin
        miss_valid = 1'b1;
        miss_addr  = addr ^ 32'h0000_0100;
      end
      cyc();
      req_ready  = 1'b0;
      miss_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin
        cyc();
        chk(early_valid == 1'b0, "R5 no early during gap", 256'(early_valid), 256'(0));
      end
      rsp_valid = 1'b1;
      rsp_data  = mdat(ca);
      cyc();
      rsp_valid = 1'b0;
      if (n == 0) begin
        chk(early_valid == 1'b1, "R5 early strobe", 256'(early_valid), 256'(1));
        chk(early_data == mdat(ca), "R5 early data", 256'(early_data), 256'(mdat(ca)));
        chk(early_addr == line, "R5 early addr", 256'(early_addr), 256'(line));
      end else begin
        chk(early_valid == 1'b0, "R5 early only once", 256'(early_valid), 256'(0));
      end
      chk(busy == 1'b1, "R1 busy during fill", 256'(busy), 256'(1));
      if (n < 3) begin
        chk(arr_we == 1'b0, "R7 no early write", 256'(arr_we), 256'(0));
      end else begin
        chk(arr_we == 1'b1, "R7 write after last beat", 256'(arr_we), 256'(1));
        chk(arr_addr == line, "R7 write addr", 256'(arr_addr), 256'(line));
        chk(arr_data == exp_line, "R6 line assembly", arr_data, exp_line);
      end
    end
    cyc();
    chk(arr_we == 1'b0, "R7 write one cycle", 256'(arr_we), 256'(0));
    chk(busy == 1'b0, "R1 busy drops", 256'(busy), 256'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk);
    chk(!busy && !req_valid && !early_valid && !arr_we, "R9 in reset",
        256'({busy, req_valid, early_valid, arr_we}), 256'(0));
    rst_n = 1'b1;
    cyc();
    chk(!busy && !req_valid && !early_valid && !arr_we, "R9 after reset",
        256'({busy, req_valid, early_valid, arr_we}), 256'(0));

    for (int v = 0; v < 8; v++)
      do_fill(VEC[v][35:4], int'(VEC[v][3:2]), int'(VEC[v][1:0]), 1'b0, 1'b0);

    // R2 miss while busy is refused
    do_fill(32'h0000_4A30, 1, 1, 1'b0, 1'b1);

    // R8 beat while idle, then beat with nothing outstanding
    rsp_valid = 1'b1;
    rsp_data  = 64'h1111_2222_3333_4444;
    cyc();
    rsp_valid = 1'b0;
    chk(early_valid == 1'b0 && busy == 1'b0, "R8 idle beat ignored",
        256'({early_valid, busy}), 256'(0));
    do_fill(32'h0000_7788, 1, 0, 1'b1, 1'b0);

    // R9 reset mid-fill
    miss_valid = 1'b1;
    miss_addr  = 32'h0000_0C18;
    cyc();
    miss_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!busy && !req_valid, "R9 mid-fill reset", 256'({busy, req_valid}), 256'(0));
    cyc();
    rst_n = 1'b1;
    cyc();
    chk(!busy && !req_valid && !arr_we, "R9 idle after reset",
        256'({busy, req_valid, arr_we}), 256'(0));
    do_fill(32'h0000_0C18, 0, 0, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule